// File: doc/BRIEF.md
# Signed Phase-Offset Step Controller

This block holds the digital phase-offset setting that a downstream fine-delay line uses to move a clock edge. The setting is a signed two's-complement value bounded to a symmetric window (±255 by default). The controller runs on its own control clock and works in one of three modes, chosen by a build-time parameter: a bypass mode in which the offset is always zero, a static mode in which the offset takes a build-time constant, and a stepping mode in which the offset moves by one unit for each accepted request.

In stepping mode a requester raises the enable input for one control-clock cycle and sets the direction line: high adds one, low subtracts one. The controller is then busy for a programmable number of cycles. It then applies the step and raises a done output for a single cycle. Requests that arrive while it is busy are dropped. A request that would take the offset outside the window completes normally but leaves the offset where it was. The block produces only the setting and the handshake. The delay element itself lies outside it.

Top module: `pshift_ctrl`

## Requirements
- R1: The mode is fixed by the MODE parameter, encoded 0 = bypass, 1 = static, 2 = stepping. Each instance behaves according to its own mode.
- R2: In bypass mode the offset output is 0 at all times. Enable pulses have no effect and done is never raised.
- R3: In static mode the offset output equals FIXED_OFS clamped to ±OFS_LIMIT from reset onward. Enable pulses have no effect and done is never raised.
- R4: In stepping mode, enable sampled high at a rising clock edge while idle starts one adjustment. Direction sampled high at that edge means +1 and low means -1.
- R5: Done is high for exactly one cycle, after the DONE_LAT-th rising edge that follows the accepting edge. The offset takes its new value at that same edge and does not change at any other time.
- R6: An enable sampled while an adjustment is in progress is ignored. This includes the edge at which done rises. The edge right after that one accepts a new request.
- R7: A request that would move the offset above +OFS_LIMIT or below -OFS_LIMIT leaves the offset unchanged but still produces its done pulse on schedule.
- R8: The offset output, read as an OFS_W-bit two's-complement number, never leaves the range -OFS_LIMIT to +OFS_LIMIT.
- R9: The active-low asynchronous reset sets the offset to its mode default (FIXED_OFS clamped in static mode, 0 otherwise), forces done low and cancels any adjustment in progress. An enable at the first edge after release is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ps_clk | input | 1 | Control clock on which all adjustment inputs are sampled |
| ps_rst_n | input | 1 | Asynchronous active-low reset |
| ps_en_i | input | 1 | One-cycle request to step the offset (stepping mode only) |
| ps_inc_i | input | 1 | Step direction: 1 adds one, 0 subtracts one |
| ps_done_o | output | 1 | One-cycle pulse marking completion of an accepted request |
| phase_ofs_o | output | OFS_W | Current signed offset for the delay line |

## Verification
The bench walks the stepping offset from zero to the upper limit, then all the way down to the lower limit. At every step it checks the exact cycle of the done pulse and of the offset change. A design with an off-by-one latency, or one that updated the offset before done, fails on the first step. A design that wrapped or saturated wrongly fails at the two one-past-the-limit requests, which must keep the offset still and still raise done. Other checks fire an enable during busy, including at the very edge where done rises, and put a reset in the middle of an adjustment. A controller that queued requests, accepted them one edge early, or left a stale busy state would show a second done, a double step or a lost request. Static and bypass instances, one of them with a constant outside the window, receive the same enable traffic. This exposes any mode leakage or missing clamp.

// File: rtl/pshift_pkg.sv
`timescale 1ns/1ps
package pshift_pkg;

    typedef enum logic [1:0] {
        PS_MODE_NONE  = 2'd0,
        PS_MODE_FIXED = 2'd1,
        PS_MODE_VAR   = 2'd2
    } ps_mode_e;

    // Clamp an integer into the symmetric window [-lim, +lim].
    function automatic int clamp_ofs(input int v, input int lim);
        if (v > lim)  return lim;
        if (v < -lim) return -lim;
        return v;
    endfunction

endpackage

// File: rtl/pshift_step.sv
`timescale 1ns/1ps
// Combinational one-unit step with window check.
module pshift_step #(
    parameter int OFS_W = 9,
    parameter int LIMIT = 255
) (
    input  logic signed [OFS_W-1:0] cur_i,
    input  logic                    inc_i,
    output logic signed [OFS_W-1:0] nxt_o,
    output logic                    clip_o
);
    localparam int WW = OFS_W + 1;
    localparam logic signed [WW-1:0] LIM_POS = WW'(LIMIT);
    localparam logic signed [WW-1:0] LIM_NEG = -WW'(LIMIT);

    logic signed [WW-1:0] cur_ext;
    logic signed [WW-1:0] cand;

    always_comb begin
        cur_ext = $signed({cur_i[OFS_W-1], cur_i});
        cand    = inc_i ? (cur_ext + WW'(1)) : (cur_ext - WW'(1));
        clip_o  = (cand > LIM_POS) || (cand < LIM_NEG);
        nxt_o   = clip_o ? cur_i : cand[OFS_W-1:0];
    end

endmodule

// File: rtl/pshift_timer.sv
`timescale 1ns/1ps
// Busy window of LAT cycles; fire_o is high in the last cycle of it.
module pshift_timer #(
    parameter int LAT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic fire_o
);
    localparam int CNT_W = (LAT < 2) ? 1 : $clog2(LAT);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_s;

    tmr_s tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.busy) begin
            if (tmr_q.cnt == '0) tmr_d.busy = 1'b0;
            else                 tmr_d.cnt  = tmr_q.cnt - CNT_W'(1);
        end else if (start_i) begin
            tmr_d.busy = 1'b1;
            tmr_d.cnt  = CNT_W'(LAT - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign busy_o = tmr_q.busy;
    assign fire_o = tmr_q.busy && (tmr_q.cnt == '0);

endmodule

// File: rtl/pshift_ctrl.sv
`timescale 1ns/1ps
// Signed phase-offset setting with mode selection and step handshake.
module pshift_ctrl
    import pshift_pkg::*;
#(
    parameter ps_mode_e MODE      = PS_MODE_VAR,
    parameter int       OFS_W     = 9,
    parameter int       OFS_LIMIT = 255,
    parameter int       FIXED_OFS = 0,
    parameter int       DONE_LAT  = 3
) (
    input  logic                    ps_clk,
    input  logic                    ps_rst_n,
    input  logic                    ps_en_i,
    input  logic                    ps_inc_i,
    output logic                    ps_done_o,
    output logic signed [OFS_W-1:0] phase_ofs_o
);
    localparam logic [OFS_W-1:0] DEF_OFS =
        (MODE == PS_MODE_FIXED) ? OFS_W'(clamp_ofs(FIXED_OFS, OFS_LIMIT)) : '0;

    typedef struct packed {
        logic [OFS_W-1:0] ofs;
        logic             inc;
        logic             done;
    } ctl_s;

    ctl_s ctl_d, ctl_q;

    logic                    busy;
    logic                    fire;
    logic                    accept;
    logic signed [OFS_W-1:0] step_nxt;
    logic                    step_clip;

    generate
        if (MODE == PS_MODE_VAR) begin : g_var
            assign accept = ps_en_i && !busy;
        end else begin : g_static
            assign accept = 1'b0;
        end
    endgenerate

    pshift_timer #(.LAT(DONE_LAT)) u_timer (
        .clk     (ps_clk),
        .rst_n   (ps_rst_n),
        .start_i (accept),
        .busy_o  (busy),
        .fire_o  (fire)
    );

    pshift_step #(.OFS_W(OFS_W), .LIMIT(OFS_LIMIT)) u_step (
        .cur_i  ($signed(ctl_q.ofs)),
        .inc_i  (ctl_q.inc),
        .nxt_o  (step_nxt),
        .clip_o (step_clip)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        if (accept) ctl_d.inc = ps_inc_i;
        if (fire) begin
            // A clipped request keeps the old value (step_nxt == current).
            ctl_d.ofs  = step_clip ? ctl_q.ofs : step_nxt;
            ctl_d.done = 1'b1;
        end
    end

    always_ff @(posedge ps_clk or negedge ps_rst_n) begin
        if (!ps_rst_n) begin
            ctl_q.ofs  <= DEF_OFS;
            ctl_q.inc  <= 1'b0;
            ctl_q.done <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ps_done_o   = ctl_q.done;
    assign phase_ofs_o = $signed(ctl_q.ofs);

endmodule

// File: rtl/pshift_ctrl_chk.sv
`timescale 1ns/1ps
module pshift_ctrl_chk
    import pshift_pkg::*;
#(
    parameter ps_mode_e MODE      = PS_MODE_VAR,
    parameter int       OFS_W     = 9,
    parameter int       OFS_LIMIT = 255,
    parameter int       FIXED_OFS = 0
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    done,
    input logic signed [OFS_W-1:0] ofs
);
    localparam logic signed [OFS_W:0] LIM_P = (OFS_W+1)'(OFS_LIMIT);
    localparam logic signed [OFS_W:0] LIM_N = -(OFS_W+1)'(OFS_LIMIT);
    localparam logic signed [OFS_W-1:0] EXP_STATIC =
        (MODE == PS_MODE_FIXED) ? OFS_W'(clamp_ofs(FIXED_OFS, OFS_LIMIT)) : '0;

    logic signed [OFS_W:0] ofs_ext;
    assign ofs_ext = $signed({ofs[OFS_W-1], ofs});

    assert_ofs_in_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ofs_ext <= LIM_P) && (ofs_ext >= LIM_N));

    assert_done_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_ofs_moves_only_on_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(ofs));

    assert_unit_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ofs == $past(ofs)) || (ofs == $past(ofs) + OFS_W'(1))
              || (ofs == $past(ofs) - OFS_W'(1)));

    generate
        if (MODE != PS_MODE_VAR) begin : g_static_chk
            assert_static_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
                ofs == EXP_STATIC);
            assert_static_no_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
                !done);
        end
    endgenerate

endmodule

bind pshift_ctrl pshift_ctrl_chk #(
    .MODE      (MODE),
    .OFS_W     (OFS_W),
    .OFS_LIMIT (OFS_LIMIT),
    .FIXED_OFS (FIXED_OFS)
) u_chk (
    .clk   (ps_clk),
    .rst_n (ps_rst_n),
    .done  (ps_done_o),
    .ofs   (phase_ofs_o)
);

// File: tb/tb_pshift_ctrl.sv
`timescale 1ns/1ps
module tb_pshift_ctrl;
    import pshift_pkg::*;

    localparam int W   = 9;
    localparam int LIM = 255;
    localparam int LAT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic inc = 1'b0;

    logic signed [W-1:0] ofs_var, ofs_fix, ofs_clip, ofs_none;
    logic done_var, done_fix, done_clip, done_none;

    int checks = 0;
    int fails = 0;
    int model = 0;
    bit other_done_seen = 1'b0;

    always #10 clk = ~clk;

    pshift_ctrl #(.MODE(PS_MODE_VAR), .OFS_W(W), .OFS_LIMIT(LIM), .FIXED_OFS(0), .DONE_LAT(LAT)) dut (
        .ps_clk(clk), .ps_rst_n(rst_n), .ps_en_i(en), .ps_inc_i(inc),
        .ps_done_o(done_var), .phase_ofs_o(ofs_var));
    pshift_ctrl #(.MODE(PS_MODE_FIXED), .OFS_W(W), .OFS_LIMIT(LIM), .FIXED_OFS(-37), .DONE_LAT(LAT)) dut_fix (
        .ps_clk(clk), .ps_rst_n(rst_n), .ps_en_i(en), .ps_inc_i(inc),
        .ps_done_o(done_fix), .phase_ofs_o(ofs_fix));
    pshift_ctrl #(.MODE(PS_MODE_FIXED), .OFS_W(W), .OFS_LIMIT(LIM), .FIXED_OFS(400), .DONE_LAT(LAT)) dut_clip (
        .ps_clk(clk), .ps_rst_n(rst_n), .ps_en_i(en), .ps_inc_i(inc),
        .ps_done_o(done_clip), .phase_ofs_o(ofs_clip));
    pshift_ctrl #(.MODE(PS_MODE_NONE), .OFS_W(W), .OFS_LIMIT(LIM), .FIXED_OFS(100), .DONE_LAT(LAT)) dut_none (
        .ps_clk(clk), .ps_rst_n(rst_n), .ps_en_i(en), .ps_inc_i(inc),
        .ps_done_o(done_none), .phase_ofs_o(ofs_none));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // R2 / R3: static instances never pulse done.
    always @(negedge clk) begin
        if (rst_n && (done_fix || done_clip || done_none)) other_done_seen = 1'b1;
    end

    task automatic check_static();
        chk(ofs_fix == -37, "R3 static offset", int'(ofs_fix), -37);
        chk(ofs_clip == 255, "R3 static clamp", int'(ofs_clip), 255);
        chk(ofs_none == 0, "R2 bypass offset", int'(ofs_none), 0);
    endtask

    // Called at a negedge; issues one request and follows it to its done cycle.
    task automatic step(input bit dir);
        int old_v = model;
        int new_v = dir ? model + 1 : model - 1;
        if (new_v > LIM || new_v < -LIM) new_v = model;   // R7
        en  = 1'b1;
        inc = dir;
        @(posedge clk);
        @(negedge clk);
        en = 1'b0;
        chk(done_var == 1'b0, "R5 no early done", int'(done_var), 0);
        for (int j = 1; j <= LAT; j++) begin
            @(negedge clk);
            if (j < LAT) begin
                chk(done_var == 1'b0, "R5 done latency", int'(done_var), 0);
                chk(ofs_var == old_v, "R5 offset held until done", int'(ofs_var), old_v);
            end else begin
                chk(done_var == 1'b1, "R5 done after DONE_LAT edges", int'(done_var), 1);
                chk(ofs_var == new_v, (new_v == old_v) ? "R7 clipped request" : "R4 step value",
                    int'(ofs_var), new_v);
            end
        end
        model = new_v;
    endtask

    initial begin
        // Reset state (R9, R1)
        repeat (3) @(negedge clk);
        chk(ofs_var == 0, "R9 reset offset stepping", int'(ofs_var), 0);
        chk(done_var == 1'b0, "R9 reset done low", int'(done_var), 0);
        check_static();
        rst_n = 1'b1;
        @(negedge clk);

        // Sweep up to the upper limit and one past it (R4, R5, R7)
        for (int i = 0; i < LIM + 1; i++) step(1'b1);
        chk(ofs_var == LIM, "R7 upper limit hold", int'(ofs_var), LIM);
        check_static();
        // Sweep down through zero to the lower limit and one past it
        for (int i = 0; i < 2 * LIM + 1; i++) step(1'b0);
        chk(ofs_var == -LIM, "R7 lower limit hold", int'(ofs_var), -LIM);
        check_static();

        // R6: requests during busy, including the done edge, are dropped
        en = 1'b1; inc = 1'b1;
        @(posedge clk);            // accepting edge k
        @(negedge clk);
        inc = 1'b0;                // still high at edge k+1: busy
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);            // after edge k+2
        en = 1'b1; inc = 1'b1;     // sampled at edge k+3, where done rises
        @(negedge clk);
        en = 1'b0;
        chk(done_var == 1'b1, "R6 first request completes", int'(done_var), 1);
        chk(ofs_var == -LIM + 1, "R6 single step applied", int'(ofs_var), -LIM + 1);
        model = -LIM + 1;
        for (int j = 0; j < LAT + 2; j++) begin
            @(negedge clk);
            chk(done_var == 1'b0, "R6 busy request ignored", int'(done_var), 0);
            chk(ofs_var == model, "R6 offset unchanged", int'(ofs_var), model);
        end

        // R9: reset in the middle of an adjustment
        en = 1'b1; inc = 1'b1;
        @(posedge clk);
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(ofs_var == 0, "R9 reset mid-adjustment offset", int'(ofs_var), 0);
        chk(done_var == 1'b0, "R9 reset mid-adjustment done", int'(done_var), 0);
        check_static();
        rst_n = 1'b1;
        model = 0;
        for (int j = 0; j < LAT + 2; j++) begin
            @(negedge clk);
            chk(done_var == 1'b0, "R9 cancelled adjustment", int'(done_var), 0);
            chk(ofs_var == 0, "R9 offset stays default", int'(ofs_var), 0);
        end
        step(1'b0);
        chk(ofs_var == -1, "R9 busy cleared, new step works", int'(ofs_var), -1);

        // R9: request at the first edge after release is accepted
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model = 0;
        step(1'b1);
        chk(ofs_var == 1, "R9 first edge after reset accepted", int'(ofs_var), 1);

        check_static();
        chk(!other_done_seen, "R2 R3 static modes never pulse done", int'(other_done_seen), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 20);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule